// File: doc/BRIEF.md
# Data-Clock Divider Phase Alignment Monitor

This block holds the data-clock dividers of several multiplexed converters that run from one fast update clock. Each channel has a counter that divides the update clock by N to make its data clock. At power-up a counter may sit in any state. A counter can also be knocked out of step later. The block compares every channel's counter with channel 0, which is the fixed reference, in every update-clock cycle. Any channel that differs is flagged, and the block pulls it back into step by withholding update-clock pulses from its counter, one pulse per comparison window.

A mode input chooses how the data clock is used. In single-rate mode the data clock has a period of N update cycles, and only the counter value modulo N matters. In double-rate mode the data clock has a period of 2N cycles and both of its edges mark words, so the full 2N-state count has to match. A per-channel seed port lets the surrounding logic, or a bench, place any counter in any state. This models both arbitrary power-up states and upsets that happen later.

Top module: `dclk_align_mon`

## Requirements
- R1: In single-rate mode (`ddr_mode`=0) each data clock is high while its counter value modulo N is below N/2, which gives a period of N update cycles at 50% duty.
- R2: In double-rate mode (`ddr_mode`=1) each counter steps through 2N states, and the data clock is high while the counter is below N. The longest high run is therefore N cycles and the period is 2N.
- R3: A channel's counter loads its seed field `seed_val[ch*PH_W +: PH_W]` on every clock edge while `rst_n` is low, and also on any edge where `seed_we[ch]` is high. The seed write takes priority over counting.
- R4: `phase_err[ch]` is high exactly while channel ch's counter differs from channel 0's counter. The compare uses the low log2(N) bits in single-rate mode and all bits in double-rate mode. `phase_err[0]` is always 0.
- R5: A mismatched channel has one update pulse withheld from its counter on the first enabled cycle after reset or after a match. After that, one pulse is withheld per window, where a window opens on each enabled cycle in which the reference count modulo N is 0. The error clears after d withheld pulses, where d is the channel's count minus the reference count, taken modulo the compared range.
- R6: No channel loses more than one pulse within one window, and the reference counter advances on every enabled cycle.
- R7: A channel counts as aligned once it has matched through two complete windows in a row. `locked` is high only while every channel is aligned, and it drops in the same cycle that any `phase_err` rises.
- R8: Checking continues after lock. A channel knocked out of step while running is flagged and brought back without any reset.
- R9: While `en` is low no counter advances and no pulse is withheld, so every data clock holds its level, while `phase_err` still reports the mismatch.
- R10: Straight after reset `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_upd | input | 1 | Fast update clock shared by all channels |
| rst_n | input | 1 | Synchronous active-low reset; loads seeds |
| en | input | 1 | Lets counters advance and corrections happen |
| ddr_mode | input | 1 | 0 = single-rate data clock, 1 = double-rate |
| seed_val | input | NUM_CH*PH_W | Per-channel counter seed, channel ch in bits [ch*PH_W +: PH_W] |
| seed_we | input | NUM_CH | Per-channel seed load strobe |
| dclk | output | NUM_CH | Per-channel divided data clock |
| phase_err | output | NUM_CH | Per-channel phase mismatch against channel 0 |
| locked | output | 1 | All channels aligned |

## Verification
The bench builds the block with its defaults: four channels and N = 4. With these values a double-rate counter has eight states, so offsets from 1 to 7 against the reference, including the half-period offset that only double-rate mode can see, can all be set up with the seed port in a few dozen cycles. Three channels give room to run several different offsets at once in a single scenario. Each scenario's bounds on when clearing and lock happen follow from the one-pulse-per-window rule and from which state the reference counter starts in.

// File: rtl/dclk_align_pkg.sv
// Shared helpers for the data-clock alignment monitor.
// Assumes the divide ratio is a power of two and at least 2.
package dclk_align_pkg;

    // Width of a counter that spans the double-rate range 0 .. 2N-1.
    function automatic int phase_width(input int div_n);
        return $clog2(2 * div_n);
    endfunction

    // Width of the single-rate part of the count (value modulo N).
    function automatic int low_width(input int div_n);
        return $clog2(div_n);
    endfunction

endpackage

// File: rtl/dclk_div_cell.sv
// One channel's data-clock divider.
// Counts 0 .. 2N-1 when adv is high and holds otherwise.
// Loads seed during reset or on load. The data clock comes from the count:
// single-rate uses the value modulo N, double-rate uses the full count.
// Assumes DIV_N is a power of two.
module dclk_div_cell #(
    parameter int DIV_N = 4,
    parameter int PH_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            load,
    input  logic            ddr_mode,
    input  logic [PH_W-1:0] seed,
    output logic [PH_W-1:0] cnt,
    output logic            dclk
);
    localparam int LO_W = $clog2(DIV_N);
    localparam int LAST = 2 * DIV_N - 1;

    logic [PH_W-1:0] cnt_q;

    // Counter: seed load first, otherwise step with wrap at 2N-1.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= seed;
        end else if (adv) begin
            if (cnt_q == PH_W'(LAST)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Data clock level chosen by the rate mode.
    always_comb begin
        if (ddr_mode) begin
            dclk = (cnt_q < PH_W'(DIV_N));
        end else begin
            dclk = (cnt_q[LO_W-1:0] < LO_W'(DIV_N / 2));
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/dclk_phase_fix.sv
// Phase compare and pulse swallowing for one non-reference channel.
// Compares the channel count with the reference count (modulo N in
// single-rate mode, full count in double-rate mode). On a mismatch it
// withholds one advance, at most once per window that win_start opens.
// Assumes win_start is already gated by the enable.
module dclk_phase_fix #(
    parameter int DIV_N = 4,
    parameter int PH_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            ddr_mode,
    input  logic            win_start,
    input  logic [PH_W-1:0] ref_cnt,
    input  logic [PH_W-1:0] ch_cnt,
    output logic            mismatch,
    output logic            swallow
);
    localparam int LO_W = $clog2(DIV_N);

    logic armed_q;

    // Mismatch over the range that the rate mode cares about.
    always_comb begin
        if (ddr_mode) begin
            mismatch = (ch_cnt != ref_cnt);
        end else begin
            mismatch = (ch_cnt[LO_W-1:0] != ref_cnt[LO_W-1:0]);
        end
    end

    // Withhold one pulse while armed, or at the opening of a window.
    assign swallow = en && mismatch && (armed_q || win_start);

    // Arming: spent by a swallow, rearmed when each window opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (swallow) begin
            armed_q <= 1'b0;
        end else if (win_start) begin
            armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dclk_lock_track.sv
// Alignment qualifier for one channel.
// Counts complete windows without any mismatch, saturating at ALIGN_WIN.
// Any mismatch clears the count. A window counts only if the channel was
// clean from its opening to its close.
module dclk_lock_track #(
    parameter int ALIGN_WIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    input  logic win_start,
    output logic aligned
);
    localparam int GW = $clog2(ALIGN_WIN + 1);

    logic [GW-1:0] good_q;
    logic          clean_q;

    // Window counting: reset on mismatch, step at each clean window close.
    always_ff @(posedge clk) begin
        if (!rst_n || mismatch) begin
            good_q  <= '0;
            clean_q <= 1'b0;
        end else if (win_start) begin
            clean_q <= 1'b1;
            if (clean_q && good_q != GW'(ALIGN_WIN)) begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    // Aligned drops at once on a new mismatch.
    assign aligned = (good_q == GW'(ALIGN_WIN)) && !mismatch;

endmodule

// File: rtl/dclk_align_mon.sv
// Top of the data-clock alignment monitor.
// Holds NUM_CH dividers from one update clock. Channel 0 is the reference
// and always advances while enabled. Every other channel is compared with
// it, corrected by swallowing pulses, and qualified for lock.
// Assumes DIV_N is a power of two and at least 2, and NUM_CH is at least 2.
module dclk_align_mon
    import dclk_align_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DIV_N     = 4,
    parameter int ALIGN_WIN = 2,
    localparam int PH_W     = phase_width(DIV_N)
) (
    input  logic                   clk_upd,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   ddr_mode,
    input  logic [NUM_CH*PH_W-1:0] seed_val,
    input  logic [NUM_CH-1:0]      seed_we,
    output logic [NUM_CH-1:0]      dclk,
    output logic [NUM_CH-1:0]      phase_err,
    output logic                   locked
);
    localparam int LO_W = low_width(DIV_N);

    logic [PH_W-1:0]   cnt [NUM_CH];
    logic [PH_W-1:0]   ref_cnt;
    logic [NUM_CH-1:0] swallow;
    logic [NUM_CH-1:0] mismatch;
    logic [NUM_CH-1:0] aligned;
    logic              win_start;

    // Reference count and window opening (reference value modulo N is 0).
    assign ref_cnt   = cnt[0];
    assign win_start = en && (ref_cnt[LO_W-1:0] == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Divider for this channel; advance unless a pulse is swallowed.
        dclk_div_cell #(
            .DIV_N (DIV_N),
            .PH_W  (PH_W)
        ) u_div (
            .clk      (clk_upd),
            .rst_n    (rst_n),
            .adv      (en && !swallow[g]),
            .load     (seed_we[g]),
            .ddr_mode (ddr_mode),
            .seed     (seed_val[g*PH_W +: PH_W]),
            .cnt      (cnt[g]),
            .dclk     (dclk[g])
        );

        if (g == 0) begin : g_ref
            // The reference is never compared, corrected or qualified.
            assign mismatch[g] = 1'b0;
            assign swallow[g]  = 1'b0;
            assign aligned[g]  = 1'b1;
        end else begin : g_fol
            dclk_phase_fix #(
                .DIV_N (DIV_N),
                .PH_W  (PH_W)
            ) u_fix (
                .clk       (clk_upd),
                .rst_n     (rst_n),
                .en        (en),
                .ddr_mode  (ddr_mode),
                .win_start (win_start),
                .ref_cnt   (ref_cnt),
                .ch_cnt    (cnt[g]),
                .mismatch  (mismatch[g]),
                .swallow   (swallow[g])
            );

            dclk_lock_track #(
                .ALIGN_WIN (ALIGN_WIN)
            ) u_trk (
                .clk       (clk_upd),
                .rst_n     (rst_n),
                .mismatch  (mismatch[g]),
                .win_start (win_start),
                .aligned   (aligned[g])
            );
        end
    end

    assign phase_err = mismatch;
    assign locked    = &aligned;

endmodule

// File: rtl/dclk_align_mon_chk.sv
// Property checker for the alignment monitor, bound into the top.
// Watches ports plus the swallow vector, the window opening and the
// reference count.
module dclk_align_mon_chk #(
    parameter int NUM_CH = 4,
    parameter int PH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              ddr_mode,
    input logic [NUM_CH-1:0] seed_we,
    input logic [NUM_CH-1:0] dclk,
    input logic [NUM_CH-1:0] phase_err,
    input logic              locked,
    input logic [NUM_CH-1:0] swallow,
    input logic              win_start,
    input logic [PH_W-1:0]   ref_cnt
);
    // The reference moves on every enabled cycle without a reload.
    p_ref_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_we[0]) |=> !$stable(ref_cnt));

    // Lock never coexists with a flagged channel.
    p_locked_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (phase_err == '0));

    // Lock rises only after a cycle with no flagged channel.
    p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(phase_err) == '0));

    // Disabled and not reloaded: data clocks hold unless the mode changes.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && seed_we == '0) |=> ($stable(dclk) || !$stable(ddr_mode)));

    for (genvar g = 1; g < NUM_CH; g++) begin : g_sw
        logic seen_q;

        // Tracks whether this window has already used its swallow.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= 1'b0;
            end else if (win_start) begin
                seen_q <= swallow[g];
            end else if (swallow[g]) begin
                seen_q <= 1'b1;
            end
        end

        // At most one withheld pulse per window.
        p_one_swallow_per_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && !win_start) |-> !swallow[g]);

        // A pulse is withheld only from a flagged channel.
        p_swallow_needs_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
            swallow[g] |-> phase_err[g]);
    end

endmodule

bind dclk_align_mon dclk_align_mon_chk #(
    .NUM_CH (NUM_CH),
    .PH_W   (PH_W)
) u_chk (
    .clk       (clk_upd),
    .rst_n     (rst_n),
    .en        (en),
    .ddr_mode  (ddr_mode),
    .seed_we   (seed_we),
    .dclk      (dclk),
    .phase_err (phase_err),
    .locked    (locked),
    .swallow   (swallow),
    .win_start (win_start),
    .ref_cnt   (ref_cnt)
);

// File: tb/dclk_align_mon_tb.sv
// Directed bench for the alignment monitor: one task per scenario.
module dclk_align_mon_tb;
    localparam int NC  = 4;
    localparam int DN  = 4;
    localparam int PW  = 3;
    localparam int LIM = 60;

    logic           clk_upd = 1'b0;
    logic           rst_n   = 1'b0;
    logic           en      = 1'b0;
    logic           ddr_mode = 1'b0;
    logic [NC*PW-1:0] seed_val = '0;
    logic [NC-1:0]  seed_we = '0;
    logic [NC-1:0]  dclk;
    logic [NC-1:0]  phase_err;
    logic           locked;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk_upd = ~clk_upd;

    dclk_align_mon #(.NUM_CH(NC), .DIV_N(DN), .ALIGN_WIN(2)) u_dut (
        .clk_upd   (clk_upd),
        .rst_n     (rst_n),
        .en        (en),
        .ddr_mode  (ddr_mode),
        .seed_val  (seed_val),
        .seed_we   (seed_we),
        .dclk      (dclk),
        .phase_err (phase_err),
        .locked    (locked)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit lvl(input int s, input bit ddr);
        if (ddr) return (s < DN);
        return ((s % DN) < DN / 2);
    endfunction

    function automatic int offs(input int s, input int s0, input bit ddr);
        if (ddr) return (s - s0 + 2 * DN) % (2 * DN);
        return ((s % DN) - (s0 % DN) + DN) % DN;
    endfunction

    task automatic put_seeds(input int s[NC]);
        for (int c = 0; c < NC; c++) seed_val[c*PW +: PW] = PW'(s[c]);
    endtask

    // Reset with seeds, then check the state right after release (R3, R4, R10).
    task automatic do_reset(input string tag, input int s[NC], input bit ddr);
        logic [NC-1:0] ed, ep;
        rst_n = 1'b0; en = 1'b1; ddr_mode = ddr; seed_we = '0;
        put_seeds(s);
        repeat (2) @(negedge clk_upd);
        rst_n = 1'b1;
        #1;
        for (int c = 0; c < NC; c++) begin
            ed[c] = lvl(s[c], ddr);
            ep[c] = (offs(s[c], s[0], ddr) != 0);
        end
        chk(dclk == ed, "R3", {tag, " seeded data clocks"}, dclk, ed);
        chk(phase_err == ep, "R4", {tag, " initial phase_err"}, phase_err, ep);
        chk(locked == 1'b0, "R10", {tag, " locked after reset"}, locked, 0);
    endtask

    // Track clearing and lock from the current state (R5, R7).
    // Assumes each follower may swallow at once in the first sampled cycle.
    task automatic settle(input string tag, input int s[NC], input bit ddr);
        int tc[NC];
        int tl, tmax, d, lo, hi;
        bit relapse;
        tl = -1; tmax = 0; relapse = 1'b0;
        for (int c = 0; c < NC; c++) tc[c] = -1;
        for (int k = 0; k < LIM; k++) begin
            for (int c = 0; c < NC; c++) begin
                if (tc[c] < 0 && !phase_err[c]) tc[c] = k;
                else if (tc[c] >= 0 && phase_err[c]) relapse = 1'b1;
            end
            if (tl < 0 && locked) tl = k;
            @(negedge clk_upd); #1;
        end
        for (int c = 1; c < NC; c++) begin
            d = offs(s[c], s[0], ddr);
            if (d == 0) begin lo = 0; hi = 0; end
            else if (d == 1) begin lo = 1; hi = 1; end
            else begin lo = (d - 2) * DN + 2; hi = (d - 1) * DN + 1; end
            chk(tc[c] >= lo && tc[c] <= hi, "R5", $sformatf("%s ch%0d clear time", tag, c),
                tc[c], hi);
            if (tc[c] > tmax) tmax = tc[c];
        end
        chk(!relapse, "R4", {tag, " error stays clear"}, relapse, 0);
        chk(tl >= tmax + 2 * DN + 1 && tl <= tmax + 3 * DN, "R7", {tag, " lock time"},
            tl, tmax + 3 * DN);
    endtask

    // Check equal data clocks and the reference waveform shape (R1, R2).
    task automatic shape(input string tag, input bit ddr);
        int highs, run, maxrun;
        bit eq;
        highs = 0; run = 0; maxrun = 0; eq = 1'b1;
        for (int k = 0; k < 3 * DN; k++) begin
            if (dclk != {NC{dclk[0]}}) eq = 1'b0;
            if (k < 2 * DN && dclk[0]) highs++;
            run = dclk[0] ? run + 1 : 0;
            if (run > maxrun) maxrun = run;
            @(negedge clk_upd); #1;
        end
        chk(eq, ddr ? "R2" : "R1", {tag, " channels share one data clock"}, eq, 1);
        chk(highs == DN, ddr ? "R2" : "R1", {tag, " high cycles in 2N"}, highs, DN);
        chk(maxrun == (ddr ? DN : DN / 2), ddr ? "R2" : "R1", {tag, " high run"},
            maxrun, ddr ? DN : DN / 2);
    endtask

    // R1: single-rate start-up with offsets 1, 2, 3.
    task automatic t_sdr_start();
        int s[NC] = '{1, 2, 3, 0};
        do_reset("sdr start", s, 1'b0);
        settle("sdr start R1", s, 1'b0);
        shape("sdr start", 1'b0);
    endtask

    // R2: double-rate start-up with offsets 3, 6, 1.
    task automatic t_ddr_start();
        int s[NC] = '{5, 0, 3, 6};
        do_reset("ddr start", s, 1'b1);
        settle("ddr start R2", s, 1'b1);
        shape("ddr start", 1'b1);
    endtask

    // R4: half-period offset invisible in single rate, flagged after switching.
    task automatic t_mode_switch();
        int s[NC] = '{2, 6, 2, 6};
        do_reset("mode sw", s, 1'b0);
        chk(phase_err == '0, "R4", "single-rate ignores top bit", phase_err, 0);
        settle("mode sw sdr", s, 1'b0);
        ddr_mode = 1'b1;
        #1;
        chk(phase_err == 4'b1010, "R4", "double-rate flags half offset", phase_err, 4'b1010);
        chk(locked == 1'b0, "R7", "lock drops with flag", locked, 0);
        // Relative offsets are still 4, 0, 4 against the reference.
        settle("mode sw ddr", s, 1'b1);
    endtask

    // R8: upset while running, no reset.
    task automatic t_slip();
        int s[NC] = '{0, 0, 3, 0};
        put_seeds(s);
        seed_we = '1;
        @(negedge clk_upd);
        seed_we = '0;
        #1;
        chk(phase_err == 4'b0100, "R8", "slip flagged", phase_err, 4'b0100);
        chk(locked == 1'b0, "R8", "lock lost on slip", locked, 0);
        settle("slip R8", s, 1'b1);
    endtask

    // R9: disabled dividers hold and are not corrected.
    task automatic t_hold();
        int s[NC] = '{0, 6, 0, 0};
        logic [NC-1:0] d0, p0;
        bit held;
        held = 1'b1;
        en = 1'b0;
        put_seeds(s);
        seed_we = '1;
        @(negedge clk_upd);
        seed_we = '0;
        #1;
        d0 = dclk; p0 = phase_err;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_upd); #1;
            if (dclk != d0 || phase_err != p0) held = 1'b0;
        end
        chk(held, "R9", "data clocks and flags held while disabled", held, 1);
        chk(phase_err == 4'b0010, "R9", "mismatch still reported", phase_err, 4'b0010);
        chk(locked == 1'b0, "R9", "no lock while disabled", locked, 0);
        en = 1'b1;
        #1;
        settle("hold R9", s, 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        t_sdr_start();
        t_ddr_start();
        t_mode_switch();
        t_slip();
        t_hold();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_upd);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule